// File: doc/BRIEF.md
# Page-Interleaved Bank Address Mapper

This block translates a physical byte address into the coordinates a multi-bus DRAM controller needs: the bus that serves the request, and the rank, bank, row and column inside that bus. The number of active buses can be changed at run time from one to four. Interleaving happens at page granularity. Every cache line of a page therefore lands on the same bus and in the same row, which keeps the row buffer hit rate high. Consecutive pages rotate across the active buses.

The lowest address bits select a byte within a 64-byte line and play no part in the decode. The next field is the line index within a page, and it becomes the column. The remaining upper bits form the page number. The page number is divided by the active bus count: the remainder picks the bus and the quotient is the page's local number on that bus. The local number is split into bank, rank and row. The bank is then scrambled by XOR with the low row bits, so rows that share plain bank bits spread over different banks.

Results are registered and appear one clock after the request, together with a valid flag. The active bus count is given as count minus one, so every two-bit code is a legal count.

Top module: `page_bank_mapper`

## Requirements
- R1: `resValid` is low after reset. It is high exactly one cycle after a cycle with `reqValid` high, and low one cycle after a cycle with `reqValid` low.
- R2: `resCol` equals byte address bits [12:6], the line index within a 128-line page. Address bits [5:0] have no effect on any output.
- R3: The page number is address bits [31:13]. `resBus` equals the page number modulo the active bus count, where the count is `busCountM1`+1.
- R4: All lines that share a page number map to the same bus, rank, bank and row.
- R5: With `busCountM1`=0 (single bus), `resBus` is always 0 and the local page number equals the page number.
- R6: With a count of 3, the bus is a true remainder of division by 3. For example, page 5 goes to bus 2 and page 6 goes to bus 0.
- R7: The local page number is the page number divided by the count, rounded down. Its bits [3:0] hold the plain bank in bits [2:0] and the rank in bit [3]. `resRow` equals local page bits [18:4].
- R8: `resBank` equals the plain bank XOR `resRow` bits [2:0].
- R9: In a cycle after `reqValid` was low, `resBus`, `resRank`, `resBank`, `resRow` and `resCol` keep their previous values.
- R10: Every output field is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request address is valid this cycle |
| reqAddr | input | 32 | Physical byte address |
| busCountM1 | input | 2 | Number of active buses minus one |
| resValid | output | 1 | Decoded fields are valid |
| resBus | output | 2 | Target bus index |
| resRank | output | 1 | Rank within the bus |
| resBank | output | 3 | Scrambled bank index |
| resRow | output | 15 | Row within the bank |
| resCol | output | 7 | Line index within the page |

## Verification
The hardest case is a count of three. A design that slices low bits in place of a real remainder sends pages 3, 7 and others to the wrong bus, or reports bus 3. The bench therefore sweeps consecutive pages under every count. It also walks all lines of one page and changes the byte offset, so an interleave at line granularity breaks R4 and a decode that uses the offset bits breaks R2. Rows are chosen so that the XOR scramble is visible: a mapper that drops it, or mixes the rank bit into it, reports the wrong bank. Idle gaps between requests catch registers that load on every cycle and do not hold their value.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int MAX_BUSES = 4;
  localparam int BUS_W = $clog2(MAX_BUSES);

  typedef struct packed {
    logic                 load;
    logic [MAX_BUSES-1:0] divSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/pbm_control.sv
module pbm_control
  import pbm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BUS_W-1:0] busCountM1,
  output ctrlStrobes_t     strobes,
  output logic             resValid
);
  always_comb begin
    strobes.load = reqValid;
    strobes.divSel = '0;
    strobes.divSel[busCountM1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end
endmodule

// File: rtl/pbm_datapath.sv
module pbm_datapath
  import pbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int COL_W      = 7,
  parameter int BANK_W     = 3,
  parameter int RANK_W     = 1,
  localparam int PAGE_W    = ADDR_W - LINE_OFF_W - COL_W,
  localparam int ROW_W     = PAGE_W - BANK_W - RANK_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [ADDR_W-LINE_OFF_W-1:0]   lineAddr,
  output logic [BUS_W-1:0]               resBus,
  output logic [RANK_W-1:0]              resRank,
  output logic [BANK_W-1:0]              resBank,
  output logic [ROW_W-1:0]               resRow,
  output logic [COL_W-1:0]               resCol
);
  logic [PAGE_W-1:0] pageNum;
  logic [PAGE_W-1:0] quotCand [MAX_BUSES];
  logic [BUS_W-1:0]  remCand  [MAX_BUSES];
  logic [PAGE_W-1:0] localPage;
  logic [BUS_W-1:0]  busSel;
  logic [BANK_W-1:0] plainBank;
  logic [RANK_W-1:0] rankSel;
  logic [ROW_W-1:0]  rowSel;

  assign pageNum = lineAddr[ADDR_W-LINE_OFF_W-1 -: PAGE_W];

  // One constant divider per supported bus count.
  for (genvar g = 0; g < MAX_BUSES; g++) begin : gDiv
    logic [PAGE_W-1:0] fullRem;
    assign quotCand[g] = pageNum / PAGE_W'(g + 1);
    assign fullRem     = pageNum % PAGE_W'(g + 1);
    assign remCand[g]  = fullRem[BUS_W-1:0];
  end

  always_comb begin
    localPage = '0;
    busSel    = '0;
    for (int i = 0; i < MAX_BUSES; i++) begin
      if (strobes.divSel[i]) begin
        localPage = localPage | quotCand[i];
        busSel    = busSel | remCand[i];
      end
    end
  end

  assign plainBank = localPage[BANK_W-1:0];
  assign rankSel   = localPage[BANK_W +: RANK_W];
  assign rowSel    = localPage[PAGE_W-1 -: ROW_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resBus  <= '0;
      resRank <= '0;
      resBank <= '0;
      resRow  <= '0;
      resCol  <= '0;
    end else if (strobes.load) begin
      resBus  <= busSel;
      resRank <= rankSel;
      resBank <= plainBank ^ rowSel[BANK_W-1:0];
      resRow  <= rowSel;
      resCol  <= lineAddr[COL_W-1:0];
    end
  end
endmodule

// File: rtl/page_bank_mapper.sv
module page_bank_mapper
  import pbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int COL_W      = 7,
  parameter int BANK_W     = 3,
  parameter int RANK_W     = 1,
  localparam int PAGE_W    = ADDR_W - LINE_OFF_W - COL_W,
  localparam int ROW_W     = PAGE_W - BANK_W - RANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  busCountM1,
  output logic              resValid,
  output logic [BUS_W-1:0]  resBus,
  output logic [RANK_W-1:0] resRank,
  output logic [BANK_W-1:0] resBank,
  output logic [ROW_W-1:0]  resRow,
  output logic [COL_W-1:0]  resCol
);
  ctrlStrobes_t strobes;
  logic         unusedOffsetBits;

  assign unusedOffsetBits = ^reqAddr[LINE_OFF_W-1:0];

  pbm_control uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busCountM1(busCountM1),
    .strobes(strobes), .resValid(resValid)
  );

  pbm_datapath #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .COL_W(COL_W),
    .BANK_W(BANK_W), .RANK_W(RANK_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lineAddr(reqAddr[ADDR_W-1:LINE_OFF_W]),
    .resBus(resBus), .resRank(resRank), .resBank(resBank),
    .resRow(resRow), .resCol(resCol)
  );
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int ADDR_W = 32,
  parameter int LINE_OFF_W = 6,
  parameter int COL_W = 7,
  parameter int BANK_W = 3,
  parameter int RANK_W = 1,
  parameter int BUS_W = 2,
  parameter int ROW_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [BUS_W-1:0]  busCountM1,
  input logic              resValid,
  input logic [BUS_W-1:0]  resBus,
  input logic [RANK_W-1:0] resRank,
  input logic [BANK_W-1:0] resBank,
  input logic [ROW_W-1:0]  resRow,
  input logic [COL_W-1:0]  resCol
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  assert_col_from_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resCol == $past(reqAddr[LINE_OFF_W +: COL_W]));
  assert_bus_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resBus <= $past(busCountM1));
  assert_single_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busCountM1 == '0) |=> resBus == '0);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(resBus) && $stable(resRank) && $stable(resBank)
                   && $stable(resRow) && $stable(resCol)));
endmodule

bind page_bank_mapper pbm_checker #(
  .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .COL_W(COL_W),
  .BANK_W(BANK_W), .RANK_W(RANK_W), .BUS_W(pbm_pkg::BUS_W), .ROW_W(ROW_W)
) uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .busCountM1(busCountM1), .resValid(resValid), .resBus(resBus),
  .resRank(resRank), .resBank(resBank), .resRow(resRow), .resCol(resCol)
);

// File: tb/sim_page_bank_mapper.sv
`timescale 1ns/1ps
module sim_page_bank_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  busCountM1 = '0;
  logic        resValid;
  logic [1:0]  resBus;
  logic [0:0]  resRank;
  logic [2:0]  resBank;
  logic [14:0] resRow;
  logic [6:0]  resCol;

  int testsRun = 0;
  int testsFailed = 0;
  bit started = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  bus;
    logic        rank;
    logic [2:0]  bank;
    logic [14:0] row;
    logic [6:0]  col;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp = '0;

  always #5 clk = ~clk;

  page_bank_mapper u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busCountM1(busCountM1), .resValid(resValid), .resBus(resBus),
    .resRank(resRank), .resBank(resBank), .resRow(resRow), .resCol(resCol)
  );

  // Reference model written from R2, R3, R7 and R8.
  function automatic exp_t model(input logic [31:0] a, input logic [1:0] m1);
    exp_t e;
    logic [18:0] page, lp;
    int cnt;
    cnt  = int'(m1) + 1;
    page = a[31:13];
    lp   = 19'(int'(page) / cnt);
    e.bus  = 2'(int'(page) % cnt);
    e.rank = lp[3];
    e.row  = lp[18:4];
    e.bank = lp[2:0] ^ lp[6:4];
    e.col  = a[12:6];
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] m1, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; busCountM1 = m1;
    expQ.push_back(model(a, m1));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0;
      reqAddr = 32'hDEAD_BEEF;
      busCountM1 = 2'd2;
    end
  endtask

  // Monitor: compares each result against the queue, checks held fields when idle.
  always @(posedge clk) begin
    #2;
    if (started && !done) begin
      if (resValid) begin
        if (expQ.size() == 0) check(0, "R1", "unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          check(resBus == e.bus, "R3/R6", "bus", resBus, e.bus);
          check(resCol == e.col, "R2", "col", resCol, e.col);
          check(resRow == e.row && resRank == e.rank, "R7", "row/rank",
                {resRow, resRank}, {e.row, e.rank});
          check(resBank == e.bank, "R8", "bank", resBank, e.bank);
          lastExp = e;
        end
      end else if (expQ.size() == 0) begin
        check({resBus, resRank, resBank, resRow, resCol} == lastExp, "R9", "held fields",
              {resBus, resRank, resBank, resRow, resCol}, lastExp);
      end
    end
  end

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1, R10: reset state
    check(resValid == 1'b0, "R1", "reset valid", resValid, 0);
    check({resBus, resRank, resBank, resRow, resCol} == '0, "R10", "reset fields",
          {resBus, resRank, resBank, resRow, resCol}, 0);
    started = 1;

    // R5: single bus, sweep pages
    for (int p = 0; p < 20; p++) send({19'(p * 37), 7'(p), 6'(p)}, 2'd0, "R5");
    idle(2);
    // R3/R6: consecutive pages under every count
    for (int m = 1; m < 4; m++)
      for (int p = 0; p < 24; p++) send({19'(p), 7'd5, 6'd0}, 2'(m), "R6");
    idle(3);
    // R4/R2: all lines of one page, varied byte offsets, count 3
    for (int l = 0; l < 128; l++) send({19'h2A5F3, 7'(l), 6'(l * 7)}, 2'd2, "R4");
    idle(1);
    // R8: rows with distinct low bits, count 2 and 4
    for (int r = 0; r < 16; r++) send({15'(r * 3 + 1), 4'(r), 7'd0, 6'd0}, 2'd1, "R8");
    for (int r = 0; r < 16; r++) send({15'(r), 4'(15 - r), 7'd127, 6'd63}, 2'd3, "R8");
    idle(2);
    // Mixed counts with gaps (R9 holds between)
    for (int i = 0; i < 60; i++) begin
      send($urandom(), 2'($urandom()), "R3");
      if (i % 5 == 0) idle(2);
    end
    // Top of address space
    send(32'hFFFF_FFFF, 2'd2, "R7");
    send(32'hFFFF_E000, 2'd3, "R7");
    idle(4);
    check(expQ.size() == 0, "R1", "results outstanding", expQ.size(), 0);
    check(resValid == 1'b0, "R1", "valid after idle", resValid, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule